// File: doc/BRIEF.md
# Audio Channel FIFO Interrupt Unit

This block produces the interrupt and status logic for four audio channels. Each channel has a transmit FIFO and a receive FIFO, which live outside the block and are seen only as fill levels and access strobes. From these the block derives level flags for each FIFO. It also derives five event sources per channel: transmit request, transmit underrun, receive request, receive overrun and receive timeout.

The two request events follow the FIFO thresholds directly. Underrun, overrun and timeout are held in sticky latches until software clears them through a write-one-to-clear vector. The receive timeout counts link frames in which the receive FIFO holds data and nobody reads it, and it fires at a programmable count.

A combined status word gives each channel a 7-bit field of enabled events. A single interrupt line is the OR of that word, gated by a master enable. All pins are plain control and status signals. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `aud_irq_hub`

## Requirements
- R1: `chan_status` gives channel n a 5-bit field at bit 5n. Bit 0 is transmit at most half full (level <= DEPTH/2). Bit 1 is transmit empty (level == 0). Bit 2 is transmit full (level == DEPTH). Bit 3 is receive at least half full (level >= DEPTH/2). Bit 4 is receive full (level == DEPTH). The flags follow the level inputs in the same cycle.
- R2: The transmit request (event bit 0) equals transmit level <= DEPTH/2. The receive request (event bit 2) equals receive level >= DEPTH/2. Both follow the levels in the same cycle and are not latched.
- R3: A receive write strobe on a channel whose receive level equals DEPTH sets that channel's overrun latch (event bit 3). The latch is visible after the next clock edge and stays set after the level falls.
- R4: A transmit read strobe on a channel whose transmit level is 0 sets that channel's underrun latch (event bit 1). The latch is visible after the next clock edge and is sticky.
- R5: With a timeout limit L > 0, each `frame_tick` cycle in which the receive FIFO is non-empty and not read advances an idle count. The timeout latch (event bit 4) sets on the tick that brings the count to L, and the count then holds at L.
- R6: A receive read strobe, or an empty receive FIFO, returns the idle count to zero. A limit of 0 never sets the timeout latch.
- R7: While `clr_wr` is high, bit k*NCH+n of `clr_bits` clears latch type k of channel n. Type 0 is overrun, type 1 is underrun and type 2 is timeout. Zero bits have no effect.
- R8: When a latch is set and cleared in the same cycle, it ends set.
- R9: `all_ints` gives channel n a 7-bit field at bit 7n. Each field holds the five events, each ANDed with the matching bit of that channel's 5-bit field in `ie` (same bit positions). Field bits 5 and 6 read 0.
- R10: `irq` is high exactly when `irq_master_en` is high and some bit of `all_ints` is set.
- R11: After reset all latches and idle counts are cleared, so with no enables set `all_ints` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse per link frame |
| irq_master_en | input | 1 | Master interrupt enable |
| ie | input | NCH*5 | Per-channel event enables, aligned with event bits 0..4 |
| to_limit | input | NCH*TOW | Per-channel receive idle limit in frames |
| tx_level | input | NCH*LW | Transmit FIFO fill levels |
| rx_level | input | NCH*LW | Receive FIFO fill levels |
| tx_rd | input | NCH | Link pops the transmit FIFO |
| rx_wr | input | NCH | Link pushes into the receive FIFO |
| rx_rd | input | NCH | Consumer reads the receive FIFO |
| clr_wr | input | 1 | Clear vector strobe |
| clr_bits | input | 3*NCH | Write-one-to-clear vector |
| chan_status | output | NCH*5 | Per-channel FIFO level flags |
| all_ints | output | NCH*7 | Packed enabled events |
| irq | output | 1 | Combined interrupt |

## Verification
A vector table sweeps both FIFO levels through empty, just below half, exactly half, just above half and full on all four channels. The sweep separates off-by-one threshold errors and swapped flag positions. Access strobes are then applied to chosen channels only, and single clear bits are written. These steps show that each channel lands in its own 7-bit field and that clear bits are indexed by type and channel. The timeout is driven with the FIFO holding data, read mid-count, empty, and with a zero limit, which separates an early or late fire from a counter that is not reset. Same-cycle set and clear, masked enables and the master gate round off the interrupt path.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int EV_W      = 7;
  localparam int EV_USED   = 5;
  localparam int ST_W      = 5;
  localparam int EV_TXREQ  = 0;
  localparam int EV_UNDER  = 1;
  localparam int EV_RXREQ  = 2;
  localparam int EV_OVER   = 3;
  localparam int EV_TMO    = 4;
  localparam int ST_TXHE   = 0;
  localparam int ST_TXEMP  = 1;
  localparam int ST_TXFUL  = 2;
  localparam int ST_RXHF   = 3;
  localparam int ST_RXFUL  = 4;
  localparam int CLR_OVER  = 0;
  localparam int CLR_UNDER = 1;
  localparam int CLR_TMO   = 2;
  localparam int CLR_TYPES = 3;
endpackage

// File: rtl/aud_sticky.sv
module aud_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;   // set has priority over clear
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/aud_idle_timer.sv
module aud_idle_timer #(
  parameter int TOW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           nonempty,
  input  logic           rd,
  input  logic [TOW-1:0] limit,
  output logic           fire
);
  logic [TOW-1:0] cnt;
  logic           armed;
  logic           at_limit;

  assign armed    = (limit != '0) && nonempty && !rd;
  assign at_limit = (cnt == limit);
  assign fire     = tick && armed && (({1'b0, cnt} + 1'b1) == {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (rd || !nonempty)              cnt <= '0;
    else if (tick && armed && !at_limit)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/aud_chan_irq.sv
module aud_chan_irq
  import aud_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TOW   = 12,
  parameter int LW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic [LW-1:0]      tx_level,
  input  logic [LW-1:0]      rx_level,
  input  logic               tx_rd,
  input  logic               rx_wr,
  input  logic               rx_rd,
  input  logic [TOW-1:0]     to_limit,
  input  logic [EV_USED-1:0] ie,
  input  logic               clr_over,
  input  logic               clr_under,
  input  logic               clr_tmo,
  output logic [ST_W-1:0]    status,
  output logic [EV_W-1:0]    events,
  output logic               over_q,
  output logic               under_q
);
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic tx_he, tx_emp, tx_ful, rx_hf, rx_ful;
  logic tmo_fire, tmo_q;
  logic [EV_USED-1:0] raw;

  assign tx_he  = (tx_level <= HALF);
  assign tx_emp = (tx_level == '0);
  assign tx_ful = (tx_level == FULL);
  assign rx_hf  = (rx_level >= HALF);
  assign rx_ful = (rx_level == FULL);

  always_comb begin
    status           = '0;
    status[ST_TXHE]  = tx_he;
    status[ST_TXEMP] = tx_emp;
    status[ST_TXFUL] = tx_ful;
    status[ST_RXHF]  = rx_hf;
    status[ST_RXFUL] = rx_ful;
  end

  aud_sticky u_over  (.clk(clk), .rst_n(rst_n), .set(rx_wr && rx_ful),
                      .clr(clr_over), .q(over_q));
  aud_sticky u_under (.clk(clk), .rst_n(rst_n), .set(tx_rd && tx_emp),
                      .clr(clr_under), .q(under_q));

  aud_idle_timer #(.TOW(TOW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick),
    .nonempty(rx_level != '0), .rd(rx_rd), .limit(to_limit), .fire(tmo_fire)
  );
  aud_sticky u_tmo (.clk(clk), .rst_n(rst_n), .set(tmo_fire),
                    .clr(clr_tmo), .q(tmo_q));

  always_comb begin
    raw           = '0;
    raw[EV_TXREQ] = tx_he;
    raw[EV_UNDER] = under_q;
    raw[EV_RXREQ] = rx_hf;
    raw[EV_OVER]  = over_q;
    raw[EV_TMO]   = tmo_q;
    events        = {{(EV_W-EV_USED){1'b0}}, raw & ie};
  end
endmodule

// File: rtl/aud_irq_hub.sv
module aud_irq_hub
  import aud_irq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  parameter int TOW   = 12,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int CLRW = CLR_TYPES * NCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_tick,
  input  logic                   irq_master_en,
  input  logic [NCH*EV_USED-1:0] ie,
  input  logic [NCH*TOW-1:0]     to_limit,
  input  logic [NCH*LW-1:0]      tx_level,
  input  logic [NCH*LW-1:0]      rx_level,
  input  logic [NCH-1:0]         tx_rd,
  input  logic [NCH-1:0]         rx_wr,
  input  logic [NCH-1:0]         rx_rd,
  input  logic                   clr_wr,
  input  logic [CLRW-1:0]        clr_bits,
  output logic [NCH*ST_W-1:0]    chan_status,
  output logic [NCH*EV_W-1:0]    all_ints,
  output logic                   irq
);
  logic [NCH-1:0] over_q;
  logic [NCH-1:0] under_q;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    aud_chan_irq #(.DEPTH(DEPTH), .TOW(TOW), .LW(LW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_tick(frame_tick),
      .tx_level  (tx_level[n*LW +: LW]),
      .rx_level  (rx_level[n*LW +: LW]),
      .tx_rd     (tx_rd[n]),
      .rx_wr     (rx_wr[n]),
      .rx_rd     (rx_rd[n]),
      .to_limit  (to_limit[n*TOW +: TOW]),
      .ie        (ie[n*EV_USED +: EV_USED]),
      .clr_over  (clr_wr && clr_bits[CLR_OVER*NCH + n]),
      .clr_under (clr_wr && clr_bits[CLR_UNDER*NCH + n]),
      .clr_tmo   (clr_wr && clr_bits[CLR_TMO*NCH + n]),
      .status    (chan_status[n*ST_W +: ST_W]),
      .events    (all_ints[n*EV_W +: EV_W]),
      .over_q    (over_q[n]),
      .under_q   (under_q[n])
    );
  end

  assign irq = irq_master_en && (|all_ints);
endmodule

// File: rtl/aud_irq_hub_chk.sv
module aud_irq_hub_chk
  import aud_irq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   irq_master_en,
  input logic [NCH*EV_USED-1:0] ie,
  input logic [NCH*LW-1:0]      tx_level,
  input logic [NCH*LW-1:0]      rx_level,
  input logic [NCH-1:0]         tx_rd,
  input logic [NCH-1:0]         rx_wr,
  input logic                   clr_wr,
  input logic [CLR_TYPES*NCH-1:0] clr_bits,
  input logic [NCH-1:0]         over_q,
  input logic [NCH-1:0]         under_q,
  input logic [NCH*EV_W-1:0]    all_ints,
  input logic                   irq
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);

  // R10: no interrupt without the master enable
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_master_en);

  for (genvar n = 0; n < NCH; n++) begin : g_c
    // R3: overrun condition is latched at the next edge
    p_over_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_wr[n] && rx_level[n*LW +: LW] == FULL) |=> over_q[n]);
    // R4: underrun condition is latched at the next edge
    p_under_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rd[n] && tx_level[n*LW +: LW] == '0) |=> under_q[n]);
    // R7: a pending overrun stays unless its own clear bit is written
    p_over_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (over_q[n] && !(clr_wr && clr_bits[CLR_OVER*NCH + n])) |=> over_q[n]);
    // R7: clear drops the latch when no new event arrives
    p_over_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_bits[CLR_OVER*NCH + n] &&
       !(rx_wr[n] && rx_level[n*LW +: LW] == FULL)) |=> !over_q[n]);
    // R2: transmit request tracks the level under its enable
    p_txreq_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      all_ints[n*EV_W + EV_TXREQ] ==
        (ie[n*EV_USED + EV_TXREQ] && (tx_level[n*LW +: LW] <= HALF)));
    // R9: spare field bits stay low
    p_spare_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      all_ints[n*EV_W + EV_USED +: (EV_W-EV_USED)] == '0);
  end
endmodule

bind aud_irq_hub aud_irq_hub_chk #(.NCH(NCH), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_master_en(irq_master_en), .ie(ie),
  .tx_level(tx_level), .rx_level(rx_level), .tx_rd(tx_rd), .rx_wr(rx_wr),
  .clr_wr(clr_wr), .clr_bits(clr_bits), .over_q(over_q), .under_q(under_q),
  .all_ints(all_ints), .irq(irq)
);

// File: tb/sim_aud_irq_hub.sv
`timescale 1ns/1ps
module sim_aud_irq_hub;
  localparam int NCH = 4, DEPTH = 8, TOW = 12, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0, irq_master_en = 1'b0;
  logic [NCH*5-1:0]   ie = '0;
  logic [NCH*TOW-1:0] to_limit = '0;
  logic [NCH*LW-1:0]  tx_level = '0, rx_level = '0;
  logic [NCH-1:0]     tx_rd = '0, rx_wr = '0, rx_rd = '0;
  logic               clr_wr = 1'b0;
  logic [3*NCH-1:0]   clr_bits = '0;
  logic [NCH*5-1:0]   chan_status;
  logic [NCH*7-1:0]   all_ints;
  logic               irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aud_irq_hub #(.NCH(NCH), .DEPTH(DEPTH), .TOW(TOW)) u0 (.*);

  // {tx_level, rx_level, expected 5-bit status}
  localparam logic [12:0] VEC [8] = '{
    {4'd0, 4'd0, 5'd3},  {4'd3, 4'd3, 5'd1},  {4'd4, 4'd4, 5'd9},
    {4'd5, 4'd5, 5'd8},  {4'd8, 4'd8, 5'd28}, {4'd0, 4'd8, 5'd27},
    {4'd8, 4'd0, 5'd4},  {4'd4, 4'd7, 5'd9}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit ev(input int c, input int b);
    return all_ints[7*c + b];
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      frame_tick = 1'b1; cyc(); frame_tick = 1'b0; cyc();
    end
  endtask

  task automatic clear(input logic [3*NCH-1:0] v);
    clr_wr = 1'b1; clr_bits = v; cyc(); clr_wr = 1'b0; clr_bits = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    cyc(); rst_n = 1'b1; #1;
    // R11: reset state
    check(all_ints == '0, "R11 all_ints after reset", int'(all_ints), 0);
    check(irq == 1'b0, "R11 irq after reset", int'(irq), 0);
    ie = {NCH{5'b11010}}; #1;
    check(all_ints == '0, "R11 sticky latches clear", int'(all_ints), 0);

    // R1 / R2: vector table
    ie = {NCH{5'b00101}};
    foreach (VEC[i]) begin
      cyc();
      tx_level = {NCH{VEC[i][12:9]}};
      rx_level = {NCH{VEC[i][8:5]}};
      #1;
      for (int c = 0; c < NCH; c++) begin
        check(chan_status[5*c +: 5] == VEC[i][4:0], "R1 status flags",
              int'(chan_status[5*c +: 5]), int'(VEC[i][4:0]));
        check(ev(c, 0) == VEC[i][0] && ev(c, 2) == VEC[i][3], "R2 request events",
              int'(all_ints[7*c +: 7]), int'({VEC[i][3], 1'b0, VEC[i][0]}));
      end
    end

    // R3: overrun on channels 0 and 2 only
    cyc();
    tx_level = {NCH{4'd6}};
    rx_level = {4'd2, 4'd8, 4'd2, 4'd8};
    ie = {NCH{5'b11010}};
    rx_wr = '1; cyc(); rx_wr = '0;
    rx_level = {NCH{4'd2}}; #1;
    for (int c = 0; c < NCH; c++)
      check(ev(c, 3) == (c == 0 || c == 2), "R3 overrun latched and sticky",
            int'(ev(c, 3)), int'(c == 0 || c == 2));

    // R7: clear overrun ch2 (bit 2) and underrun ch0 (bit 4)
    clear(12'h014); #1;
    check(ev(2, 3) == 1'b0, "R7 clear ch2 overrun", int'(ev(2, 3)), 0);
    check(ev(0, 3) == 1'b1, "R7 ch0 overrun untouched", int'(ev(0, 3)), 1);

    // R4: underrun on channel 3 only
    tx_level = {4'd0, 4'd6, 4'd6, 4'd6};
    tx_rd = '1; cyc(); tx_rd = '0;
    tx_level = {NCH{4'd6}}; #1;
    for (int c = 0; c < NCH; c++)
      check(ev(c, 1) == (c == 3), "R4 underrun latched", int'(ev(c, 1)), int'(c == 3));
    clear(12'h080); #1;
    check(ev(3, 1) == 1'b0, "R7 clear ch3 underrun (bit 7)", int'(ev(3, 1)), 0);

    // R8: set wins over clear-all in the same cycle
    rx_level = {4'd2, 4'd2, 4'd8, 4'd2};
    rx_wr = 4'b0010; clr_wr = 1'b1; clr_bits = '1; cyc();
    rx_wr = '0; clr_wr = 1'b0; clr_bits = '0; rx_level = {NCH{4'd2}}; #1;
    check(ev(1, 3) == 1'b1, "R8 set beats clear", int'(ev(1, 3)), 1);
    check(ev(0, 3) == 1'b0, "R7 clear-all ch0", int'(ev(0, 3)), 0);

    // R9 / R10: masking and master gate
    check(irq == 1'b0, "R10 master off", int'(irq), 0);
    irq_master_en = 1'b1; #1;
    check(irq == 1'b1, "R10 master on", int'(irq), 1);
    check(all_ints == 28'h0000400, "R9 packed field ch1 bit3",
          int'(all_ints), 32'h400);
    ie[5*1 + 3] = 1'b0; #1;
    check(ev(1, 3) == 1'b0 && irq == 1'b0, "R9 enable masks event", int'(all_ints), 0);
    ie[5*1 + 3] = 1'b1;
    cyc(); clear('1); #1;
    check(irq == 1'b0, "R10 irq after clear", int'(irq), 0);

    // R5: timeout on channel 1 with limit 3
    to_limit[TOW*1 +: TOW] = 12'd3;
    ticks(2); #1;
    check(ev(1, 4) == 1'b0, "R5 no timeout after 2 frames", int'(ev(1, 4)), 0);
    ticks(1); #1;
    check(ev(1, 4) == 1'b1, "R5 timeout on 3rd frame", int'(ev(1, 4)), 1);
    check(ev(0, 4) == 1'b0, "R5 other channel quiet", int'(ev(0, 4)), 0);
    ticks(4); clear(12'h200); ticks(2); #1;
    check(ev(1, 4) == 1'b0, "R5 no refire while held", int'(ev(1, 4)), 0);

    // R6: read restarts the count
    rx_rd[1] = 1'b1; cyc(); rx_rd[1] = 1'b0;
    ticks(2); #1;
    check(ev(1, 4) == 1'b0, "R6 count restarted by read", int'(ev(1, 4)), 0);
    ticks(1); #1;
    check(ev(1, 4) == 1'b1, "R6 fires 3 frames after read", int'(ev(1, 4)), 1);
    clear(12'h200);
    rx_level[LW*1 +: LW] = 4'd0; ticks(5); #1;
    check(ev(1, 4) == 1'b0, "R6 empty FIFO never times out", int'(ev(1, 4)), 0);
    rx_level[LW*1 +: LW] = 4'd2; to_limit[TOW*1 +: TOW] = 12'd0; ticks(6); #1;
    check(ev(1, 4) == 1'b0, "R6 zero limit disables", int'(ev(1, 4)), 0);

    report();
  end
endmodule